// File: doc/BRIEF.md
# Vectored Interrupt Sequencer

This block decides which event the processor core services next and names the address the program counter logic must call. It has three sources. Reset has the highest priority, cannot be masked, and starts execution at address 000H. An active-low external interrupt line calls 003H. A timer/counter overflow calls 007H. When the external line and the timer are both ready in the same cycle, the external request wins. The timer request stays pending until it is taken.

Taking an external or timer event sets a single in-service latch. That latch masks both maskable sources until the core reports a return-and-restore-status instruction. Handlers cannot nest, and an enable command issued inside a handler does not lift the mask.

The block also contains the 8-bit timer/counter whose rollover raises the timer request. In timer mode it advances once every 32 instruction-cycle strobes. In counter mode it advances on each synchronized falling edge of the T1 pin. It can be loaded at any time, and one halt command stops it in either mode. An overflow flag records each rollover, whether or not the timer interrupt is enabled.

Top module: `irq_vector_seq`

## Requirements
- R1: During reset, call_req, in_service, tmr_flag and tmr_value are all 0. On the first clock edge after rst_n rises, call_req pulses with call_vec = 12'h000 and in_service stays 0. No enable is needed for this call. Both interrupt enables reset to 0.
- R2: While the external enable is set and int_n is held low, a call with call_vec = 12'h003 appears on the third rising edge after int_n falls, and in_service goes to 1 on that same edge.
- R3: While the timer enable is set, a rollover of tmr_value from 8'hFF to 8'h00 is followed one edge later by a call with call_vec = 12'h007 and in_service = 1.
- R4: If the external and timer requests are both ready, the external call (12'h003) is made first. The timer request stays pending and is called (12'h007) after the next return-and-restore-status strobe.
- R5: While in_service is 1, no call is made, even if ext_en_cmd or tmr_en_cmd is pulsed. A retr_stb pulse clears in_service on the following edge.
- R6: With its enable cleared, a source never causes a call: a low int_n after ext_dis_cmd, and a rollover before tmr_en_cmd. Pulsing tmr_dis_cmd drops a timer request that is already pending, so re-enabling the timer does not bring that request back.
- R7: tmr_flag is set by every rollover, whether or not the timer interrupt is enabled. It is cleared on the edge after a tflag_test pulse and on the edge that takes the timer call.
- R8: After tmr_run_cmd, tmr_value advances by exactly 1 on every 32nd edge on which cyc_stb is high. The first step comes 32 edges after the start command.
- R9: After cnt_run_cmd, tmr_value advances by 1 on the third rising clock edge after each falling edge of t1_in. Rising edges of t1_in have no effect.
- R10: tmr_wr loads tmr_wr_data on the next edge, whether the counter is stopped, timing or counting. After halt_cmd, tmr_value holds in either mode.
- R11: call_req is high for exactly one cycle per call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| int_n | input | 1 | External interrupt line, active low, asynchronous |
| t1_in | input | 1 | Event pin for counter mode, asynchronous |
| cyc_stb | input | 1 | One pulse per instruction cycle |
| ext_en_cmd | input | 1 | Enable the external source |
| ext_dis_cmd | input | 1 | Disable the external source |
| tmr_en_cmd | input | 1 | Enable the timer source |
| tmr_dis_cmd | input | 1 | Disable the timer source and drop its pending request |
| retr_stb | input | 1 | Return-and-restore-status executed |
| tmr_run_cmd | input | 1 | Start in timer mode |
| cnt_run_cmd | input | 1 | Start in counter mode |
| halt_cmd | input | 1 | Stop the timer/counter |
| tmr_wr | input | 1 | Load the timer/counter |
| tmr_wr_data | input | 8 | Load value |
| tflag_test | input | 1 | Overflow flag tested (clears it) |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | 12 | Call target address |
| in_service | output | 1 | A maskable handler is active |
| tmr_value | output | 8 | Current timer/counter value |
| tmr_flag | output | 1 | Overflow flag |

## Verification
Every result arrives a fixed number of edges after its cause. A command or load shows one edge later. A low int_n needs two synchronizer edges plus one arbitration edge, so the call comes on the third edge. The T1 count step also lands on the third edge. A rollover's call comes one edge after the rollover itself. A timer step lands on the 32nd edge after start. The bench drives inputs 2 ns after a rising edge and reads outputs at that same point. For each latency it checks the edge just before the due edge, to see that the result has not appeared yet, and then the due edge itself. Masking windows are swept over several edges to confirm that no call appears.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {TM_STOP, TM_TIMER, TM_COUNT} tm_mode_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_RESET, SRC_EXT, SRC_TMR} src_e;

  localparam int unsigned ADDR_RESET = 0;
  localparam int unsigned ADDR_EXT   = 3;
  localparam int unsigned ADDR_TMR   = 7;

  function automatic int unsigned vec_of(src_e s);
    case (s)
      SRC_EXT: return ADDR_EXT;
      SRC_TMR: return ADDR_TMR;
      default: return ADDR_RESET;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_tmr_cnt.sv
module irq_tmr_cnt
  import irq_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic             t1_sync,
  input  logic             run_tmr,
  input  logic             run_cnt,
  input  logic             halt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] value,
  output logic             roll
);
  tm_mode_e         mode_q, mode_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic             t1_prev_q;
  logic             t1_fall, tick, pre_en, val_en;

  always_comb begin
    t1_fall = t1_prev_q & ~t1_sync;
    tick    = ((mode_q == TM_TIMER) && cyc_stb && (pre_q == {PRE_W{1'b1}})) ||
              ((mode_q == TM_COUNT) && t1_fall);

    mode_d = mode_q;
    if (halt)         mode_d = TM_STOP;
    else if (run_tmr) mode_d = TM_TIMER;
    else if (run_cnt) mode_d = TM_COUNT;

    pre_en = run_tmr || ((mode_q == TM_TIMER) && cyc_stb);
    pre_d  = run_tmr ? '0 : pre_q + 1'b1;

    val_en = wr || tick;
    val_d  = wr ? wr_data : val_q + 1'b1;

    roll   = tick && !wr && (val_q == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= TM_STOP;
      pre_q     <= '0;
      val_q     <= '0;
      t1_prev_q <= 1'b1;
    end else begin
      mode_q    <= mode_d;
      t1_prev_q <= t1_sync;
      if (pre_en) pre_q <= pre_d;
      if (val_en) val_q <= val_d;
    end
  end

  assign value = val_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_seq_pkg::*;
#(
  parameter int VEC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_req,
  input  logic             tmr_roll,
  input  logic             ext_en_cmd,
  input  logic             ext_dis_cmd,
  input  logic             tmr_en_cmd,
  input  logic             tmr_dis_cmd,
  input  logic             retr,
  input  logic             flag_test,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             in_service,
  output logic             tmr_flag
);
  logic             boot_q, ext_en_q, tmr_en_q, pend_q, isr_q, call_q, flag_q;
  logic             ext_en_d, tmr_en_d, pend_d, isr_d, call_d, flag_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             take_ok;
  src_e             sel;

  always_comb begin
    take_ok = !isr_q && !call_q;
    sel     = SRC_NONE;
    if (boot_q)                               sel = SRC_RESET;
    else if (take_ok && ext_req && ext_en_q)  sel = SRC_EXT;
    else if (take_ok && pend_q && tmr_en_q)   sel = SRC_TMR;

    ext_en_d = ext_en_q;
    if (ext_en_cmd)  ext_en_d = 1'b1;
    if (ext_dis_cmd) ext_en_d = 1'b0;

    tmr_en_d = tmr_en_q;
    if (tmr_en_cmd)  tmr_en_d = 1'b1;
    if (tmr_dis_cmd) tmr_en_d = 1'b0;

    pend_d = pend_q;
    if (sel == SRC_TMR)        pend_d = 1'b0;
    if (tmr_roll && tmr_en_d)  pend_d = 1'b1;
    if (tmr_dis_cmd)           pend_d = 1'b0;

    flag_d = flag_q;
    if (flag_test || sel == SRC_TMR) flag_d = 1'b0;
    if (tmr_roll)                    flag_d = 1'b1;

    isr_d = isr_q;
    if (sel == SRC_EXT || sel == SRC_TMR) isr_d = 1'b1;
    else if (retr)                        isr_d = 1'b0;

    call_d = (sel != SRC_NONE);
    vec_d  = VEC_W'(vec_of(sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q   <= 1'b1;
      ext_en_q <= 1'b0;
      tmr_en_q <= 1'b0;
      pend_q   <= 1'b0;
      isr_q    <= 1'b0;
      call_q   <= 1'b0;
      flag_q   <= 1'b0;
      vec_q    <= '0;
    end else begin
      boot_q   <= 1'b0;
      ext_en_q <= ext_en_d;
      tmr_en_q <= tmr_en_d;
      pend_q   <= pend_d;
      isr_q    <= isr_d;
      call_q   <= call_d;
      flag_q   <= flag_d;
      if (call_d) vec_q <= vec_d;
    end
  end

  assign call_req   = call_q;
  assign call_vec   = vec_q;
  assign in_service = isr_q;
  assign tmr_flag   = flag_q;
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq #(
  parameter int VEC_W  = 12,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_n,
  input  logic             t1_in,
  input  logic             cyc_stb,
  input  logic             ext_en_cmd,
  input  logic             ext_dis_cmd,
  input  logic             tmr_en_cmd,
  input  logic             tmr_dis_cmd,
  input  logic             retr_stb,
  input  logic             tmr_run_cmd,
  input  logic             cnt_run_cmd,
  input  logic             halt_cmd,
  input  logic             tmr_wr,
  input  logic [CNT_W-1:0] tmr_wr_data,
  input  logic             tflag_test,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             in_service,
  output logic             tmr_flag,
  output logic [CNT_W-1:0] tmr_value
);
  logic int_s, t1_s, tmr_roll;

  irq_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .rst_n(rst_n), .din(int_n), .dout(int_s));

  irq_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_t1_sync (
    .clk(clk), .rst_n(rst_n), .din(t1_in), .dout(t1_s));

  irq_tmr_cnt #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .t1_sync(t1_s),
    .run_tmr(tmr_run_cmd), .run_cnt(cnt_run_cmd), .halt(halt_cmd),
    .wr(tmr_wr), .wr_data(tmr_wr_data), .value(tmr_value), .roll(tmr_roll));

  irq_arb #(.VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .ext_req(~int_s), .tmr_roll(tmr_roll),
    .ext_en_cmd(ext_en_cmd), .ext_dis_cmd(ext_dis_cmd),
    .tmr_en_cmd(tmr_en_cmd), .tmr_dis_cmd(tmr_dis_cmd),
    .retr(retr_stb), .flag_test(tflag_test),
    .call_req(call_req), .call_vec(call_vec),
    .in_service(in_service), .tmr_flag(tmr_flag));
endmodule

// File: rtl/irq_vector_seq_chk.sv
module irq_vector_seq_chk #(
  parameter int VEC_W = 12,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             call_req,
  input logic [VEC_W-1:0] call_vec,
  input logic             in_service,
  input logic             retr_stb,
  input logic             tmr_wr,
  input logic             halt_cmd,
  input logic [CNT_W-1:0] tmr_value,
  input logic             tmr_flag,
  input logic             tmr_roll
);
  // R11
  call_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && !retr_stb) |=> (!call_req && in_service));

  // R1
  boot_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !in_service) |-> (call_vec == VEC_W'(0)));

  // R2
  isr_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && in_service) |-> (call_vec == VEC_W'(3) || call_vec == VEC_W'(7)));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_roll |=> tmr_flag);

  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr |=> (tmr_value == $past(tmr_value) || tmr_value == $past(tmr_value) + 1'b1));

  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cmd ##1 !tmr_wr) |=> $stable(tmr_value));
endmodule

bind irq_vector_seq irq_vector_seq_chk #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_vec(call_vec),
  .in_service(in_service), .retr_stb(retr_stb), .tmr_wr(tmr_wr),
  .halt_cmd(halt_cmd), .tmr_value(tmr_value), .tmr_flag(tmr_flag),
  .tmr_roll(tmr_roll));

// File: tb/sim_irq_vector_seq.sv
`timescale 1ns/1ps
module sim_irq_vector_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_n = 1'b1, t1_in = 1'b1, cyc_stb = 1'b1;
  logic ext_en_cmd = 0, ext_dis_cmd = 0, tmr_en_cmd = 0, tmr_dis_cmd = 0;
  logic retr_stb = 0, tmr_run_cmd = 0, cnt_run_cmd = 0, halt_cmd = 0;
  logic tmr_wr = 0, tflag_test = 0;
  logic [7:0]  tmr_wr_data = 8'h00;
  logic        call_req, in_service, tmr_flag;
  logic [11:0] call_vec;
  logic [7:0]  tmr_value;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_vector_seq u0 (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .t1_in(t1_in), .cyc_stb(cyc_stb),
    .ext_en_cmd(ext_en_cmd), .ext_dis_cmd(ext_dis_cmd),
    .tmr_en_cmd(tmr_en_cmd), .tmr_dis_cmd(tmr_dis_cmd), .retr_stb(retr_stb),
    .tmr_run_cmd(tmr_run_cmd), .cnt_run_cmd(cnt_run_cmd), .halt_cmd(halt_cmd),
    .tmr_wr(tmr_wr), .tmr_wr_data(tmr_wr_data), .tflag_test(tflag_test),
    .call_req(call_req), .call_vec(call_vec), .in_service(in_service),
    .tmr_flag(tmr_flag), .tmr_value(tmr_value));

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // n edges with no call request
  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (call_req) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic expect_call(input string tag, input int vec);
    chk({tag, " call_req"}, call_req, 1);
    chk({tag, " call_vec"}, call_vec, vec);
    chk({tag, " in_service"}, in_service, 1);
  endtask

  task automatic retr();
    retr_stb = 1; tick(); retr_stb = 0;
  endtask

  task automatic load_run(input logic [7:0] v, input bit timer);
    tmr_wr = 1; tmr_wr_data = v;
    if (timer) tmr_run_cmd = 1; else cnt_run_cmd = 1;
    tick();
    tmr_wr = 0; tmr_run_cmd = 0; cnt_run_cmd = 0;
  endtask

  task automatic halt();
    halt_cmd = 1; tick(); halt_cmd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    // R1 reset state
    tick(); tick();
    chk("R1 reset call_req", call_req, 0);
    chk("R1 reset in_service", in_service, 0);
    chk("R1 reset tmr_value", tmr_value, 0);
    chk("R1 reset tmr_flag", tmr_flag, 0);
    rst_n = 1;
    tick();
    chk("R1 boot call_req", call_req, 1);
    chk("R1 boot call_vec", call_vec, 0);
    chk("R1 boot in_service", in_service, 0);
    tick();
    chk("R11 boot pulse width", call_req, 0);
    quiet(4, "R1 no call with enables cleared");

    // R2 external call, 3 edge latency
    ext_en_cmd = 1; tick(); ext_en_cmd = 0;
    int_n = 0;
    tick(); tick();
    chk("R2 not before third edge", call_req, 0);
    tick();
    expect_call("R2 ext", 12'h003);
    tick();
    chk("R11 ext pulse width", call_req, 0);
    quiet(5, "R5 masked while in service");
    ext_en_cmd = 1; tick(); ext_en_cmd = 0;
    quiet(4, "R5 enable does not unmask");
    int_n = 1; tick(); tick(); tick();
    retr();
    chk("R5 retr clears in_service", in_service, 0);
    quiet(4, "R2 no call with int_n high");

    // R6 disabled external source
    ext_dis_cmd = 1; tick(); ext_dis_cmd = 0;
    int_n = 0;
    quiet(8, "R6 external disabled");
    int_n = 1; tick(); tick(); tick();

    // R8 timer mode sweep, R7 flag without enable
    load_run(8'hFD, 1'b1);
    for (int k = 1; k <= 3; k++) begin
      repeat (31) tick();
      chk("R8 before step", tmr_value, 8'(8'hFD + k - 1));
      tick();
      chk("R8 on 32nd edge", tmr_value, 8'(8'hFD + k));
    end
    chk("R7 flag set with interrupt disabled", tmr_flag, 1);
    chk("R6 no timer call while disabled", call_req, 0);
    quiet(3, "R6 rollover before enable never calls");
    tflag_test = 1; tick(); tflag_test = 0;
    chk("R7 flag cleared by test", tmr_flag, 0);
    tmr_wr = 1; tmr_wr_data = 8'h33; tick(); tmr_wr = 0;
    chk("R10 load while timing", tmr_value, 8'h33);

    // R10 halt and load while stopped
    halt();
    held = tmr_value;
    repeat (70) tick();
    chk("R10 halted timer holds", tmr_value, held);
    tmr_wr = 1; tmr_wr_data = 8'h5A; tick(); tmr_wr = 0;
    chk("R10 load while stopped", tmr_value, 8'h5A);

    // R3 timer interrupt
    tmr_en_cmd = 1; tick(); tmr_en_cmd = 0;
    load_run(8'hFF, 1'b1);
    repeat (31) tick();
    chk("R3 value before rollover", tmr_value, 8'hFF);
    tick();
    chk("R3 rolled to zero", tmr_value, 8'h00);
    chk("R3 no call on rollover edge", call_req, 0);
    chk("R7 flag on rollover", tmr_flag, 1);
    tick();
    expect_call("R3 timer", 12'h007);
    chk("R7 flag cleared by ack", tmr_flag, 0);
    halt();
    retr();
    chk("R5 retr clears after timer", in_service, 0);

    // R4 both pending: external first, timer kept
    ext_en_cmd = 1; tick(); ext_en_cmd = 0;
    int_n = 0;
    tick(); tick(); tick();
    expect_call("R4 setup ext", 12'h003);
    load_run(8'hFF, 1'b1);
    quiet(33, "R5 rollover masked in service");
    halt();
    retr();
    tick();
    expect_call("R4 external first", 12'h003);
    int_n = 1; tick(); tick(); tick();
    retr();
    tick();
    expect_call("R4 timer kept pending", 12'h007);
    retr();

    // R6 timer disable drops pending request
    int_n = 0;
    tick(); tick(); tick();
    expect_call("R6 setup ext", 12'h003);
    int_n = 1;
    load_run(8'hFF, 1'b1);
    repeat (33) tick();
    halt();
    tmr_dis_cmd = 1; tick(); tmr_dis_cmd = 0;
    tmr_en_cmd = 1; tick(); tmr_en_cmd = 0;
    retr();
    quiet(6, "R6 dropped timer request not called");
    chk("R7 flag survives disable", tmr_flag, 1);
    tflag_test = 1; tick(); tflag_test = 0;

    // R9 counter mode
    load_run(8'h10, 1'b0);
    for (int i = 0; i < 5; i++) begin
      t1_in = 0;
      tick(); tick();
      chk("R9 count not before third edge", tmr_value, 8'h10 + i);
      tick();
      chk("R9 count on fall", tmr_value, 8'h10 + i + 1);
      t1_in = 1;
      tick(); tick(); tick();
      chk("R9 rising edge ignored", tmr_value, 8'h10 + i + 1);
    end
    tmr_wr = 1; tmr_wr_data = 8'h77; tick(); tmr_wr = 0;
    chk("R10 load while counting", tmr_value, 8'h77);
    halt();
    for (int i = 0; i < 2; i++) begin
      t1_in = 0; tick(); tick(); tick();
      t1_in = 1; tick(); tick(); tick();
    end
    chk("R10 halted counter holds", tmr_value, 8'h77);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule